// File: doc/BRIEF.md
# Linked-Ring Capture DMA Address Walker

This block steers a capture stream into host memory. Buffer pages are listed in a ring of table pages. The first word of each table page holds the page number of the next table page. The words that follow hold the page numbers of the buffer pages, in the order they are filled. The host programs the page number of the first table and issues a start command. The block then fetches each table's descriptors over a simple word-addressed memory request port. It writes every incoming 32-bit capture word into the current buffer, in ascending order, so that the last word of a buffer always lands last. The host can therefore poll that last word to learn that the buffer is complete.

The walk is throttled by a credit counter that counts whole tables. The host clears or tops up the counter with commands. The block spends one credit each time it enters a table. With no credit it waits on the table boundary and writes nothing. Capture words that arrive while the block cannot take them are discarded. Each discard raises an overflow indication, and that indication is marked on the next word that is written. A stop command returns the block to idle.

Top module: `ring_dma_walker`

## Requirements
- R1: After reset the block is idle (`st_busy`=0), `st_credits` is 0, `st_overflow` is 0 and `mem_req_valid` stays low.
- R2: A write with `reg_sel`=0 is a command. Bit 0 clears the credit count and bit 1 adds one credit. When both bits are set, the clear wins. The count saturates at its maximum (2^CRED_W-1).
- R3: A write with `reg_sel`=1 loads the start table page number. A command with bit 2 set then starts the walk from that page. The block begins a table only when it holds at least one credit, and it spends exactly one credit when it issues the read of that table's word 0.
- R4: The memory word address is page number × 2^WORD_IDX_W + word index. For each table the block reads word 0 (the next pointer) first, then word i (i = 1..BUFS) just before filling buffer i.
- R5: Capture words are written to word indices 0 to 2^WORD_IDX_W-1 of the current buffer page, in arrival order and ascending address. The next descriptor read is issued only after the write of the last word has been accepted.
- R6: After buffer BUFS of a table is filled, the walk continues with the table named by that table's word 0.
- R7: When a table boundary is reached with zero credits, `st_stalled` is high and no memory request is issued until a credit is added.
- R8: A capture word offered while the walk is running but `st_accepting` is low is not written, and `st_overflow` is set on the next cycle.
- R9: The first word written after one or more discards carries `mem_req_flag`=1, and `st_overflow` clears. Later words carry 0 until the next discard.
- R10: A command with bit 3 set stops the walk, and stop wins over start in the same write. Once the block is idle it issues no requests, and capture words are ignored without setting overflow.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request (address, data, write enable) is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: command, 1: start table page |
| reg_wdata | input | 32 | Register write data |
| cap_valid | input | 1 | Capture word present this cycle |
| cap_data | input | DATA_W | Capture word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1: write, 0: read |
| mem_req_addr | output | PAGE_W+WORD_IDX_W | Word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_flag | output | 1 | Written word follows a discard |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Read data |
| st_busy | output | 1 | Walk running |
| st_stalled | output | 1 | Waiting for a table credit |
| st_accepting | output | 1 | A capture word offered now is taken |
| st_overflow | output | 1 | Discard seen, not yet flagged |
| st_credits | output | CRED_W | Table credits held |

## Verification
Command and start-register writes take effect on the next clock edge, so `st_credits` and `st_busy` are sampled one edge after the strobe. An accepted capture word appears on the request port one edge after it is offered, and a discard shows on `st_overflow` one edge later. Each descriptor read completes one cycle after its handshake, so the next request follows after a fixed number of cycles. The bench drives at the falling edge and samples at the falling edge after the relevant rising edge. It also logs every request handshake at the rising edge and compares that log, entry by entry, against the address and data sequence derived from the ring contents.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_CREDIT,
      S_WT_NEXT,
      S_WT_BUF,
      S_FILL,
      S_DRAIN
   } rdw_state_e;

   localparam int CMD_CLR   = 0;
   localparam int CMD_ADD   = 1;
   localparam int CMD_START = 2;
   localparam int CMD_STOP  = 3;

   localparam logic SEL_CMD   = 1'b0;
   localparam logic SEL_START = 1'b1;
endpackage

// File: rtl/rdw_credit.sv
module rdw_credit #(
   parameter int CRED_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic              take,
   output logic [CRED_W-1:0] cnt,
   output logic              nz
);
   localparam logic [CRED_W-1:0] MAXV = {CRED_W{1'b1}};

   logic [CRED_W-1:0] inc_val;

   generate
      if (SATURATE) begin : g_sat
         assign inc_val = (cnt == MAXV) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign inc_val = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (add && !take) begin
         cnt <= inc_val;
      end else if (take && !add) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign nz = (cnt != '0);

   // R2
   credit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R3
   credit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cnt != '0));

   generate
      if (SATURATE) begin : g_sat_chk
         // R2
         credit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (add && !clr && !take && cnt == MAXV) |=> (cnt == MAXV));
      end
   endgenerate
endmodule

// File: rtl/rdw_ovf.sv
module rdw_ovf (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_valid,
   input  logic busy,
   input  logic accept,
   output logic ovf_q
);
   logic drop;

   assign drop = cap_valid && busy && !accept;

   always_ff @(posedge clk) begin
      if (!rst_n)      ovf_q <= 1'b0;
      else if (drop)   ovf_q <= 1'b1;
      else if (accept) ovf_q <= 1'b0;
   end

   // R8
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_q);
   // R9
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ovf_q);
   // R10
   ovf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !accept) |=> (ovf_q == $past(ovf_q)));
endmodule

// File: rtl/rdw_walk.sv
module rdw_walk
   import rdw_pkg::*;
#(
   parameter int PAGE_W     = 32,
   parameter int WORD_IDX_W = 10,
   parameter int BUFS       = 511,
   parameter int DATA_W     = 32,
   localparam int ADDR_W    = PAGE_W + WORD_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic [PAGE_W-1:0] start_pg,
   input  logic              credit_nz,
   output logic              take,
   input  logic              cap_valid,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              ovf_flag,
   output logic              accept,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   output logic              mem_req_flag,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              busy,
   output logic              stalled,
   output logic              can_take
);
   localparam logic [WORD_IDX_W-1:0] LAST_W = {WORD_IDX_W{1'b1}};
   localparam logic [WORD_IDX_W-1:0] LAST_B = WORD_IDX_W'(BUFS);

   rdw_state_e              state;
   logic [PAGE_W-1:0]       cur_tbl, nxt_tbl, buf_pg;
   logic [WORD_IDX_W-1:0]   buf_idx, word_idx;
   logic                    stop_q;
   logic                    hold, stop_pend, stop_go, rsp_ok;

   assign hold      = mem_req_valid && !mem_req_ready;
   assign stop_pend = stop_q || stop_cmd;
   assign stop_go   = stop_pend && !hold;
   assign rsp_ok    = mem_rsp_valid && !mem_req_valid;
   assign can_take  = (state == S_FILL) && !hold && !stop_pend;
   assign accept    = can_take && cap_valid;
   assign take      = (state == S_CREDIT) && credit_nz && !stop_pend;
   assign busy      = (state != S_IDLE);
   assign stalled   = (state == S_CREDIT) && !credit_nz;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= S_IDLE;
         cur_tbl       <= '0;
         nxt_tbl       <= '0;
         buf_pg        <= '0;
         buf_idx       <= '0;
         word_idx      <= '0;
         stop_q        <= 1'b0;
         mem_req_valid <= 1'b0;
         mem_req_we    <= 1'b0;
         mem_req_addr  <= '0;
         mem_req_wdata <= '0;
         mem_req_flag  <= 1'b0;
      end else begin
         if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
         if (stop_go) begin
            state         <= S_IDLE;
            stop_q        <= 1'b0;
            mem_req_valid <= 1'b0;
         end else begin
            if (stop_cmd) stop_q <= 1'b1;
            unique case (state)
               S_IDLE: begin
                  if (start_cmd) begin
                     cur_tbl <= start_pg;
                     state   <= S_CREDIT;
                  end
               end
               S_CREDIT: begin
                  if (take) begin
                     mem_req_valid <= 1'b1;
                     mem_req_we    <= 1'b0;
                     mem_req_flag  <= 1'b0;
                     mem_req_addr  <= {cur_tbl, {WORD_IDX_W{1'b0}}};
                     state         <= S_WT_NEXT;
                  end
               end
               S_WT_NEXT: begin
                  if (rsp_ok) begin
                     nxt_tbl       <= mem_rsp_data[PAGE_W-1:0];
                     buf_idx       <= WORD_IDX_W'(1);
                     mem_req_valid <= 1'b1;
                     mem_req_we    <= 1'b0;
                     mem_req_addr  <= {cur_tbl, WORD_IDX_W'(1)};
                     state         <= S_WT_BUF;
                  end
               end
               S_WT_BUF: begin
                  if (rsp_ok) begin
                     buf_pg   <= mem_rsp_data[PAGE_W-1:0];
                     word_idx <= '0;
                     state    <= S_FILL;
                  end
               end
               S_FILL: begin
                  if (accept) begin
                     mem_req_valid <= 1'b1;
                     mem_req_we    <= 1'b1;
                     mem_req_addr  <= {buf_pg, word_idx};
                     mem_req_wdata <= cap_data;
                     mem_req_flag  <= ovf_flag;
                     word_idx      <= word_idx + 1'b1;
                     if (word_idx == LAST_W) state <= S_DRAIN;
                  end
               end
               S_DRAIN: begin
                  if (!hold) begin
                     if (buf_idx == LAST_B) begin
                        cur_tbl <= nxt_tbl;
                        state   <= S_CREDIT;
                     end else begin
                        buf_idx       <= buf_idx + 1'b1;
                        mem_req_valid <= 1'b1;
                        mem_req_we    <= 1'b0;
                        mem_req_flag  <= 1'b0;
                        mem_req_addr  <= {cur_tbl, buf_idx + 1'b1};
                        state         <= S_WT_BUF;
                     end
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (mem_req_valid && $stable(mem_req_addr) &&
                $stable(mem_req_wdata) && $stable(mem_req_we)));
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);
   // R7
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> !mem_req_valid);
   // R5
   drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_we) |-> (state != S_FILL));
endmodule

// File: rtl/ring_dma_walker.sv
module ring_dma_walker
   import rdw_pkg::*;
#(
   parameter int PAGE_W       = 32,
   parameter int WORD_IDX_W   = 10,
   parameter int BUFS         = 511,
   parameter int DATA_W       = 32,
   parameter int CRED_W       = 8,
   parameter bit CRED_SATURATE = 1'b1,
   localparam int ADDR_W      = PAGE_W + WORD_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic              cap_valid,
   input  logic [DATA_W-1:0] cap_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   output logic              mem_req_flag,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              st_busy,
   output logic              st_stalled,
   output logic              st_accepting,
   output logic              st_overflow,
   output logic [CRED_W-1:0] st_credits
);
   generate
      if (BUFS < 1 || BUFS >= (1 << WORD_IDX_W)) begin : g_bad_bufs
         $error("BUFS must be 1 .. 2**WORD_IDX_W-1");
      end
      if (PAGE_W > 32 || PAGE_W > DATA_W) begin : g_bad_page
         $error("PAGE_W must fit the register and data words");
      end
      if (CRED_W < 1) begin : g_bad_cred
         $error("CRED_W must be at least 1");
      end
   endgenerate

   logic              cmd_wr, cmd_clr, cmd_add, cmd_start, cmd_stop;
   logic [PAGE_W-1:0] start_pg_q;
   logic              credit_nz, take, accept, ovf_q;

   assign cmd_wr    = reg_we && (reg_sel == SEL_CMD);
   assign cmd_clr   = cmd_wr && reg_wdata[CMD_CLR];
   assign cmd_add   = cmd_wr && reg_wdata[CMD_ADD];
   assign cmd_stop  = cmd_wr && reg_wdata[CMD_STOP];
   assign cmd_start = cmd_wr && reg_wdata[CMD_START] && !reg_wdata[CMD_STOP];

   always_ff @(posedge clk) begin
      if (!rst_n)                             start_pg_q <= '0;
      else if (reg_we && reg_sel == SEL_START) start_pg_q <= reg_wdata[PAGE_W-1:0];
   end

   rdw_credit #(.CRED_W(CRED_W), .SATURATE(CRED_SATURATE)) u_credit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd_clr),
      .add   (cmd_add),
      .take  (take),
      .cnt   (st_credits),
      .nz    (credit_nz)
   );

   rdw_ovf u_ovf (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_valid (cap_valid),
      .busy      (st_busy),
      .accept    (accept),
      .ovf_q     (ovf_q)
   );

   rdw_walk #(
      .PAGE_W(PAGE_W), .WORD_IDX_W(WORD_IDX_W), .BUFS(BUFS), .DATA_W(DATA_W)
   ) u_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_cmd     (cmd_start),
      .stop_cmd      (cmd_stop),
      .start_pg      (start_pg_q),
      .credit_nz     (credit_nz),
      .take          (take),
      .cap_valid     (cap_valid),
      .cap_data      (cap_data),
      .ovf_flag      (ovf_q),
      .accept        (accept),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_we    (mem_req_we),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_req_flag  (mem_req_flag),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .busy          (st_busy),
      .stalled       (st_stalled),
      .can_take      (st_accepting)
   );

   assign st_overflow = ovf_q;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!mem_req_valid && !st_busy && st_credits == '0));
endmodule

// File: tb/ring_dma_walker_bench.sv
module ring_dma_walker_bench;
   localparam int PW = 16;
   localparam int IW = 3;
   localparam int NB = 3;
   localparam int CW = 3;
   localparam int AW = PW + IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic          reg_sel = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic          cap_valid = 1'b0;
   logic [31:0]   cap_data = '0;
   logic          mem_req_valid, mem_req_we, mem_req_flag;
   logic          mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic [31:0]   mem_req_wdata;
   logic          mem_rsp_valid = 1'b0;
   logic [31:0]   mem_rsp_data = '0;
   logic          st_busy, st_stalled, st_accepting, st_overflow;
   logic [CW-1:0] st_credits;

   always #5 clk = ~clk;

   ring_dma_walker #(.PAGE_W(PW), .WORD_IDX_W(IW), .BUFS(NB), .DATA_W(32),
                     .CRED_W(CW)) u_ring_dma_walker (.*);

   // ring: table 100 -> 200 -> 100; buffer i of table T is page T*16+i
   function automatic logic [31:0] tbl_word(input logic [AW-1:0] a);
      logic [PW-1:0] pg;
      logic [IW-1:0] ix;
      pg = a[AW-1:IW];
      ix = a[IW-1:0];
      if (ix == 0) return (pg == 16'd100) ? 32'd200 : 32'd100;
      return 32'(pg) * 32'd16 + 32'(ix);
   endfunction

   function automatic logic [AW-1:0] wa(input int pg, input int ix);
      return {PW'(pg), IW'(ix)};
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_we;
      mem_rsp_data  <= tbl_word(mem_req_addr);
   end

   logic [AW-1:0] lg_addr [256];
   logic [31:0]   lg_data [256];
   logic          lg_we   [256];
   logic          lg_flag [256];
   int            lg_n = 0;
   int            lidx = 0;

   always @(posedge clk) begin
      if (rst_n && mem_req_valid && mem_req_ready && lg_n < 256) begin
         lg_addr[lg_n] <= mem_req_addr;
         lg_data[lg_n] <= mem_req_wdata;
         lg_we[lg_n]   <= mem_req_we;
         lg_flag[lg_n] <= mem_req_flag;
         lg_n          <= lg_n + 1;
      end
   end

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_log(input string req, input bit we, input logic [AW-1:0] a,
                          input logic [31:0] d, input bit fl);
      if (lidx >= lg_n) begin
         chk(req, "missing request entry", lg_n, lidx + 1);
      end else begin
         chk(req, "request kind", lg_we[lidx], we);
         chk(req, "request address", lg_addr[lidx], a);
         if (we) begin
            chk(req, "write data", lg_data[lidx], d);
            chk(req, "write flag", lg_flag[lidx], fl);
         end
      end
      lidx++;
   endtask

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic send_raw(input logic [31:0] d);
      cap_valid = 1'b1; cap_data = d;
      @(negedge clk);
      cap_valid = 1'b0;
   endtask

   task automatic send_word(input string req, input logic [31:0] d);
      int n = 0;
      while (!st_accepting && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (n >= 200) chk(req, "accepting timeout", 0, 1);
      send_raw(d);
   endtask

   task automatic fill_buffer(input string req, input int pg, input logic [31:0] base,
                              input bit first_flag);
      for (int k = 0; k < (1 << IW); k++) send_word(req, base + 32'(k));
      repeat (2) @(negedge clk);
      for (int k = 0; k < (1 << IW); k++)
         chk_log(req, 1'b1, wa(pg, k), base + 32'(k), first_flag && k == 0);
   endtask

   task automatic t_reset;
      // R1
      chk("R1", "busy after reset", st_busy, 0);
      chk("R1", "credits after reset", st_credits, 0);
      chk("R1", "overflow after reset", st_overflow, 0);
      repeat (3) @(negedge clk);
      chk("R1", "no request after reset", lg_n, 0);
   endtask

   task automatic t_credits;
      // R2
      repeat (3) reg_write(1'b0, 32'h2);
      @(negedge clk);
      chk("R2", "three increments", st_credits, 3);
      reg_write(1'b0, 32'h1);
      chk("R2", "clear", st_credits, 0);
      repeat (9) reg_write(1'b0, 32'h2);
      chk("R2", "saturation", st_credits, 7);
      reg_write(1'b0, 32'h3);
      chk("R2", "clear beats add", st_credits, 0);
   endtask

   task automatic t_stall_start;
      // R3 R7 R8
      reg_write(1'b1, 32'd100);
      reg_write(1'b0, 32'h4);
      repeat (5) @(negedge clk);
      chk("R3", "busy after start", st_busy, 1);
      chk("R7", "stalled without credit", st_stalled, 1);
      chk("R7", "no request while stalled", lg_n, 0);
      send_raw(32'hDEAD_0001);
      chk("R8", "overflow after discard", st_overflow, 1);
      repeat (2) @(negedge clk);
      chk("R8", "discarded word not written", lg_n, 0);
   endtask

   task automatic t_first_buffer;
      // R3 R4 R5 R9
      reg_write(1'b0, 32'h2);
      repeat (8) @(negedge clk);
      chk("R3", "credit spent on table entry", st_credits, 0);
      chk_log("R4", 1'b0, wa(100, 0), 0, 0);
      chk_log("R4", 1'b0, wa(100, 1), 0, 0);
      fill_buffer("R5", 1601, 32'hA000_0000, 1'b1);
      chk("R9", "overflow cleared after flagged word", st_overflow, 0);
   endtask

   task automatic t_ring;
      // R4 R5 R6 R7
      chk_log("R4", 1'b0, wa(100, 2), 0, 0);
      fill_buffer("R5", 1602, 32'hB000_0000, 1'b0);
      chk_log("R4", 1'b0, wa(100, 3), 0, 0);
      fill_buffer("R5", 1603, 32'hC000_0000, 1'b0);
      repeat (10) @(negedge clk);
      chk("R7", "stalled at table boundary", st_stalled, 1);
      chk("R7", "no request at boundary", lg_n, lidx);
      reg_write(1'b0, 32'h2);
      repeat (8) @(negedge clk);
      chk_log("R6", 1'b0, wa(200, 0), 0, 0);
      chk_log("R6", 1'b0, wa(200, 1), 0, 0);
      fill_buffer("R6", 3201, 32'hD000_0000, 1'b0);
   endtask

   task automatic t_backpressure;
      // R11 R8 R9
      int n = 0;
      while (!st_accepting && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk_log("R4", 1'b0, wa(200, 2), 0, 0);
      mem_req_ready = 1'b0;
      send_raw(32'hE000_0000);
      send_raw(32'hE000_0001);
      chk("R8", "overflow under backpressure", st_overflow, 1);
      for (int c = 0; c < 3; c++) begin
         chk("R11", "request held valid", mem_req_valid, 1);
         chk("R11", "request address held", mem_req_addr, wa(3202, 0));
         chk("R11", "request data held", mem_req_wdata, 32'hE000_0000);
         @(negedge clk);
      end
      mem_req_ready = 1'b1;
      send_word("R9", 32'hE000_0002);
      repeat (2) @(negedge clk);
      chk_log("R11", 1'b1, wa(3202, 0), 32'hE000_0000, 1'b0);
      chk_log("R9", 1'b1, wa(3202, 1), 32'hE000_0002, 1'b1);
   endtask

   task automatic t_stop;
      // R10
      int n0;
      reg_write(1'b0, 32'h8);
      @(negedge clk);
      chk("R10", "idle after stop", st_busy, 0);
      n0 = lg_n;
      send_raw(32'hF000_0000);
      repeat (10) @(negedge clk);
      chk("R10", "no request after stop", lg_n, n0);
      chk("R10", "idle capture ignored", st_overflow, 0);
      reg_write(1'b0, 32'h2);
      reg_write(1'b0, 32'hC);
      repeat (5) @(negedge clk);
      chk("R10", "stop wins over start", st_busy, 0);
      chk("R10", "no request after stop+start", lg_n, n0);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_credits();
      t_stall_start();
      t_first_buffer();
      t_ring();
      t_backpressure();
      t_stop();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule